// File: doc/BRIEF.md
# Random Word Generator Peripheral

This block is a register-mapped source of 32-bit random words for software. A free-running linear feedback shift register stands in for the physical entropy source. Each new word appears after a fixed fill time, and a ready flag announces it. Reading the data register consumes the word, and the next one follows after the same fill time.

Software tunes the generator through a control register. The tuning fields are taken only when they come in the same write that raises the conditioning-reset bit. The noise-source and health-test registers hold plain settings. A sticky lock freezes all of this until the next system reset.

A test input injects seed faults, which stop generation. Recovery takes one of two paths: the hardware recovers by itself, or software runs a conditioning reset. A fault that arrives while a word is waiting turns that word into zero. A second test input models a clock that is too slow. The interrupt-style flags stay set until software writes zero to them.

Top module: `rng_periph`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0x00F00D00, the status register (0x04) reads 0, the noise-source register (0x0C) reads 0x2B5BB and the health-test register (0x10) reads 0x0000969D.
- R2: With the enable bit (control bit 2) set, status bit 0 (ready) rises GEN_CYCLES clocks after the last data read. A read of the data register (0x08) returns a nonzero word and clears ready at that clock edge. Two words read in sequence differ.
- R3: Control bits [29:4] are loaded only by a control write that also has bit 30 set. Any other control write leaves them unchanged.
- R4: Control bit 30 reads 1 from the write that sets it until COND_CYCLES clocks after the write that clears it, and then reads 0. While bit 30 reads 1, ready stays 0.
- R5: A seed fault sets status bit 2 (seed current) and status bit 6 (seed flag), and no new word becomes ready while bit 2 is set. When the fault does not recover by itself, a full conditioning-reset sequence clears bit 2 and generation resumes.
- R6: A seed fault injected with auto-recovery clears status bit 2 AUTO_CYCLES clocks later. Bit 6 stays set.
- R7: A status write clears bit 6 or bit 5 where the written bit is 0, and leaves a flag that is written 1 unchanged.
- R8: A seed fault that arrives while ready is 1 turns the pending word into 0, so the next data read returns 0.
- R9: While control bit 5 is 0, the slow-clock input sets status bit 1 (clock current) and status bit 5 (clock flag). Bit 1 follows the input one clock late. While control bit 5 is 1, the input has no effect.
- R10: Control bit 31 (lock) can be set but cannot be cleared by writes. While it is set, writes to control bits [29:4], to 0x0C and to 0x10 are ignored.
- R11: The noise-source register keeps only its low 18 bits, and the unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe for one clock |
| busRead | input | 1 | Read strobe; consumes the word when it addresses 0x08 |
| busAddr | input | ADDR_W | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for busAddr, combinational |
| seedFault | input | 1 | Injects a seed fault |
| seedFaultAuto | input | 1 | Qualifies seedFault: the fault recovers by itself |
| clkFault | input | 1 | Slow-clock condition |

## Verification
The hardest state to reach is a seed fault that lands exactly while a finished word is waiting. The bench lets a word mature and leaves it unread, then pulses the fault input. It confirms the zero word and the stalled ready flag, and then walks the conditioning-reset recovery. The auto-recovery path is reached the other way round: the bench drains the pending word first and injects the fault while ready is 0. The behavioural model in the bench tracks both paths clock by clock.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int OFS_CR   = 'h00;
  localparam int OFS_SR   = 'h04;
  localparam int OFS_DR   = 'h08;
  localparam int OFS_NSCR = 'h0C;
  localparam int OFS_HTCR = 'h10;

  localparam int BIT_EN      = 2;
  localparam int BIT_CEDDIS  = 5;
  localparam int CFG_LSB     = 4;
  localparam int CFG_MSB     = 29;
  localparam int BIT_CONDRST = 30;
  localparam int BIT_LOCK    = 31;
  localparam int BIT_CEIS    = 5;
  localparam int BIT_SEIS    = 6;

  localparam logic [CFG_MSB-CFG_LSB:0] CFG_RESET = 26'h00F00D0;
  localparam logic [31:0] HTCR_RESET = 32'h0000_969D;
  localparam logic [31:0] NSCR_RESET = 32'h0002_B5BB;

  typedef enum logic [1:0] {CR_IDLE, CR_HELD, CR_DRAIN} cond_phase_e;

  typedef struct packed {
    logic genRun;
    logic dataPop;
    logic lateZero;
    logic flush;
  } dp_strobe_t;
endpackage

// File: rtl/rng_datapath.sv
module rng_datapath
  import rng_pkg::*;
#(
  parameter int GEN_CYCLES = 8,
  parameter logic [31:0] LFSR_SEED = 32'hACE1_2468,
  parameter logic [31:0] LFSR_TAPS = 32'h8020_0003
) (
  input  logic       clk,
  input  logic       rstN,
  input  dp_strobe_t strobe,
  output logic       dpReady,
  output logic [31:0] dpWord
);
  localparam int GEN_CW = $clog2(GEN_CYCLES + 1);

  logic [31:0] lfsr;
  logic [GEN_CW-1:0] genCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr <= LFSR_SEED;
    end else begin
      lfsr <= (lfsr >> 1) ^ (lfsr[0] ? LFSR_TAPS : 32'h0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpReady <= 1'b0;
      dpWord  <= '0;
      genCnt  <= '0;
    end else if (strobe.flush) begin
      dpReady <= 1'b0;
      dpWord  <= '0;
      genCnt  <= '0;
    end else begin
      if (strobe.lateZero) dpWord <= '0;
      if (strobe.dataPop && dpReady) begin
        dpReady <= 1'b0;
        genCnt  <= '0;
      end else if (!dpReady && strobe.genRun) begin
        if (genCnt == GEN_CW'(GEN_CYCLES - 1)) begin
          dpReady <= 1'b1;
          dpWord  <= lfsr;
          genCnt  <= '0;
        end else begin
          genCnt <= genCnt + GEN_CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rng_ctrl.sv
module rng_ctrl
  import rng_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int NSCR_W      = 18,
  parameter int COND_CYCLES = 6,
  parameter int AUTO_CYCLES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       wrData,
  input  logic              seedFault,
  input  logic              seedFaultAuto,
  input  logic              clkFault,
  input  logic              dpReady,
  input  logic [31:0]       dpWord,
  output dp_strobe_t        strobe,
  output logic [31:0]       rdData,
  output logic [31:0]       crView,
  output logic [31:0]       srView
);
  localparam int COND_CW = $clog2(COND_CYCLES + 1);
  localparam int AUTO_CW = $clog2(AUTO_CYCLES + 1);
  localparam int CFG_W   = CFG_MSB - CFG_LSB + 1;

  cond_phase_e       phase;
  logic [COND_CW-1:0] condCnt;
  logic [AUTO_CW-1:0] autoCnt;
  logic [CFG_W-1:0]  cfgReg;
  logic [NSCR_W-1:0] nscrReg;
  logic [31:0]       htcrReg;
  logic enOn, lockOn, secs, seis, cecs, ceis, autoActive;

  logic hitCr, hitSr, hitDr, hitNs, hitHt;
  logic wrCr, wrSr, wrCondRaise, cedOn, condDone, autoDone, faultTake;

  assign hitCr = busAddr == ADDR_W'(OFS_CR);
  assign hitSr = busAddr == ADDR_W'(OFS_SR);
  assign hitDr = busAddr == ADDR_W'(OFS_DR);
  assign hitNs = busAddr == ADDR_W'(OFS_NSCR);
  assign hitHt = busAddr == ADDR_W'(OFS_HTCR);
  assign wrCr  = busWrite && hitCr;
  assign wrSr  = busWrite && hitSr;
  assign wrCondRaise = wrCr && wrData[BIT_CONDRST];
  assign cedOn = !cfgReg[BIT_CEDDIS-CFG_LSB];
  assign condDone = (phase == CR_DRAIN) && (condCnt == COND_CW'(COND_CYCLES - 1)) && !wrCondRaise;
  assign autoDone = autoActive && (autoCnt == AUTO_CW'(AUTO_CYCLES - 1));
  assign faultTake = seedFault && !secs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= CR_IDLE;
      condCnt <= '0;
      cfgReg  <= CFG_RESET;
      enOn    <= 1'b0;
      lockOn  <= 1'b0;
      nscrReg <= NSCR_RESET[NSCR_W-1:0];
      htcrReg <= HTCR_RESET;
    end else begin
      if (wrCr) begin
        lockOn <= lockOn | wrData[BIT_LOCK];
        enOn   <= wrData[BIT_EN];
      end
      if (wrCondRaise) begin
        if (!lockOn) cfgReg <= wrData[CFG_MSB:CFG_LSB];
        phase <= CR_HELD;
      end else if (wrCr && phase == CR_HELD) begin
        phase   <= CR_DRAIN;
        condCnt <= '0;
      end else if (phase == CR_DRAIN) begin
        if (condDone) phase <= CR_IDLE;
        else condCnt <= condCnt + COND_CW'(1);
      end
      if (busWrite && hitNs && !lockOn) nscrReg <= wrData[NSCR_W-1:0];
      if (busWrite && hitHt && !lockOn) htcrReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secs       <= 1'b0;
      seis       <= 1'b0;
      autoActive <= 1'b0;
      autoCnt    <= '0;
      cecs       <= 1'b0;
      ceis       <= 1'b0;
    end else begin
      if (condDone || autoDone) begin
        secs       <= 1'b0;
        autoActive <= 1'b0;
      end else if (autoActive) begin
        autoCnt <= autoCnt + AUTO_CW'(1);
      end
      if (wrSr && !wrData[BIT_SEIS]) seis <= 1'b0;
      if (faultTake) begin
        secs       <= 1'b1;
        seis       <= 1'b1;
        autoActive <= seedFaultAuto;
        autoCnt    <= '0;
      end
      cecs <= clkFault && cedOn;
      if (wrSr && !wrData[BIT_CEIS]) ceis <= 1'b0;
      if (clkFault && cedOn) ceis <= 1'b1;
    end
  end

  assign strobe.genRun   = enOn && (phase == CR_IDLE) && !secs;
  assign strobe.dataPop  = busRead && hitDr;
  assign strobe.lateZero = faultTake && dpReady;
  assign strobe.flush    = phase != CR_IDLE;

  assign crView = {lockOn, phase != CR_IDLE, cfgReg, 1'b0, enOn, 2'b00};
  assign srView = {25'b0, seis, ceis, 2'b00, secs, cecs, dpReady};

  always_comb begin
    rdData = '0;
    if (hitCr) rdData = crView;
    else if (hitSr) rdData = srView;
    else if (hitDr) rdData = dpReady ? dpWord : 32'h0;
    else if (hitNs) rdData = {{(32-NSCR_W){1'b0}}, nscrReg};
    else if (hitHt) rdData = htcrReg;
  end
endmodule

// File: rtl/rng_periph.sv
module rng_periph
  import rng_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int NSCR_W      = 18,
  parameter int GEN_CYCLES  = 8,
  parameter int COND_CYCLES = 6,
  parameter int AUTO_CYCLES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              seedFault,
  input  logic              seedFaultAuto,
  input  logic              clkFault
);
  dp_strobe_t  strobe;
  logic        dpReady;
  logic [31:0] dpWord;
  logic [31:0] crView;
  logic [31:0] srView;

  rng_ctrl #(
    .ADDR_W(ADDR_W), .NSCR_W(NSCR_W),
    .COND_CYCLES(COND_CYCLES), .AUTO_CYCLES(AUTO_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .wrData(wrData), .seedFault(seedFault),
    .seedFaultAuto(seedFaultAuto), .clkFault(clkFault),
    .dpReady(dpReady), .dpWord(dpWord), .strobe(strobe),
    .rdData(rdData), .crView(crView), .srView(srView)
  );

  rng_datapath #(.GEN_CYCLES(GEN_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .dpReady(dpReady), .dpWord(dpWord)
  );
endmodule

// File: rtl/rng_periph_chk.sv
module rng_periph_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrite,
  input logic              busRead,
  input logic [ADDR_W-1:0] busAddr,
  input logic              wrCond,
  input logic              seedFault,
  input logic              lockBit,
  input logic              busyBit,
  input logic [25:0]       cfgBits,
  input logic              readyBit,
  input logic              secsBit,
  input logic              seisBit
);
  AST_POP_CLEARS_READY: assert property (@(posedge clk) disable iff (!rstN)
    busRead && busAddr == ADDR_W'('h08) && readyBit |=> !readyBit); // R2

  AST_CFG_NEEDS_COND: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && busAddr == ADDR_W'('h00) && !wrCond |=> $stable(cfgBits)); // R3

  AST_COND_READS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && busAddr == ADDR_W'('h00) && wrCond |=> busyBit); // R4

  AST_SEED_FLAGS_SET: assert property (@(posedge clk) disable iff (!rstN)
    seedFault && !secsBit |=> secsBit && seisBit); // R5

  AST_NO_WORD_IN_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    secsBit && !readyBit |=> !readyBit); // R5

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lockBit |=> lockBit); // R10
endmodule

bind rng_periph rng_periph_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
  .busAddr(busAddr), .wrCond(wrData[30]), .seedFault(seedFault),
  .lockBit(crView[31]), .busyBit(crView[30]), .cfgBits(crView[29:4]),
  .readyBit(srView[0]), .secsBit(srView[2]), .seisBit(srView[6])
);

// File: tb/rng_periph_bench.sv
module rng_periph_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int GEN  = 8;
  localparam int COND = 6;
  localparam int AUTO = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrite = 1'b0, busRead = 1'b0;
  logic [4:0] busAddr = 5'h04;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic seedFault = 1'b0, seedFaultAuto = 1'b0, clkFault = 1'b0;

  int checks = 0, errors = 0;
  string curReq = "R1";
  bit done = 1'b0;

  rng_periph #(.GEN_CYCLES(GEN), .COND_CYCLES(COND), .AUTO_CYCLES(AUTO)) u_rng_periph (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .wrData(wrData), .rdData(rdData),
    .seedFault(seedFault), .seedFaultAuto(seedFaultAuto), .clkFault(clkFault)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  bit mReady, mZero, mSecs, mSeis, mCecs, mCeis, mAuto, mEn, mLock;
  int mGenCnt, mPhase, mCondCnt, mAutoCnt;
  logic [25:0] mCfg;
  logic [17:0] mNscr;
  logic [31:0] mHtcr;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mReady = 0; mZero = 1; mSecs = 0; mSeis = 0; mCecs = 0; mCeis = 0;
      mAuto = 0; mEn = 0; mLock = 0; mGenCnt = 0; mPhase = 0; mCondCnt = 0;
      mAutoCnt = 0; mCfg = 26'h00F00D0; mNscr = 18'h2B5BB; mHtcr = 32'h969D;
    end else begin
      bit wCr, wSr, rDr, ced, flush, gen, take, late, cdone, adone;
      wCr = busWrite && busAddr == 5'h00;
      wSr = busWrite && busAddr == 5'h04;
      rDr = busRead && busAddr == 5'h08;
      ced = !mCfg[1];
      flush = mPhase != 0;
      gen = mEn && mPhase == 0 && !mSecs;
      take = seedFault && !mSecs;
      late = take && mReady;
      cdone = mPhase == 2 && mCondCnt == COND - 1 && !(wCr && wrData[30]);
      adone = mAuto && mAutoCnt == AUTO - 1;
      if (flush) begin
        mReady = 0; mGenCnt = 0; mZero = 1;
      end else begin
        if (late) mZero = 1;
        if (rDr && mReady) begin
          mReady = 0; mGenCnt = 0;
        end else if (!mReady && gen) begin
          if (mGenCnt == GEN - 1) begin mReady = 1; mZero = 0; mGenCnt = 0; end
          else mGenCnt++;
        end
      end
      if (wCr && wrData[30]) begin
        if (!mLock) mCfg = wrData[29:4];
        mPhase = 1;
      end else if (wCr && mPhase == 1) begin
        mPhase = 2; mCondCnt = 0;
      end else if (mPhase == 2) begin
        if (cdone) mPhase = 0; else mCondCnt++;
      end
      if (wCr) begin mLock = mLock | wrData[31]; mEn = wrData[2]; end
      if (busWrite && busAddr == 5'h0C && !mLock) mNscr = wrData[17:0];
      if (busWrite && busAddr == 5'h10 && !mLock) mHtcr = wrData;
      if (cdone || adone) begin mSecs = 0; mAuto = 0; end
      else if (mAuto) mAutoCnt++;
      if (wSr && !wrData[6]) mSeis = 0;
      if (take) begin mSecs = 1; mSeis = 1; mAuto = seedFaultAuto; mAutoCnt = 0; end
      mCecs = clkFault && ced;
      if (wSr && !wrData[5]) mCeis = 0;
      if (clkFault && ced) mCeis = 1;
      #2;
      case (busAddr)
        5'h00: chk({curReq, " control model"}, rdData,
                   {mLock, mPhase != 0, mCfg, 1'b0, mEn, 2'b00});
        5'h04: chk({curReq, " status model"}, rdData,
                   {25'b0, mSeis, mCeis, 2'b00, mSecs, mCecs, mReady});
        5'h08: chk({curReq, " data nonzero model"}, {31'b0, rdData != 0},
                   {31'b0, mReady && !mZero});
        5'h0C: chk({curReq, " noise model"}, rdData, {14'b0, mNscr});
        5'h10: chk({curReq, " health model"}, rdData, mHtcr);
        default: ;
      endcase
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; wrData = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; busAddr = 5'h04;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a; busRead = 1'b1;
    #2 v = rdData;
    @(negedge clk);
    busRead = 1'b0; busAddr = 5'h04;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fault(bit autoRec);
    @(negedge clk);
    seedFault = 1'b1; seedFaultAuto = autoRec;
    @(negedge clk);
    seedFault = 1'b0; seedFaultAuto = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired during %s", curReq);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, w1, w2;
    idle(3);
    rstN = 1'b1;
    // R1 reset values
    curReq = "R1";
    rd(5'h00, v); chk("R1 control reset", v, 32'h00F00D00);
    rd(5'h04, v); chk("R1 status reset", v, 32'h0);
    rd(5'h0C, v); chk("R1 noise reset", v, 32'h0002B5BB);
    rd(5'h10, v); chk("R1 health reset", v, 32'h0000969D);
    // R11 noise register width
    curReq = "R11";
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, v); chk("R11 noise width", v, 32'h0003FFFF);
    // R2 generation and read
    curReq = "R2";
    wr(5'h00, 32'h00F00D04);
    idle(GEN + 2);
    rd(5'h04, v); chk("R2 ready set", v, 32'h1);
    rd(5'h08, w1); chk("R2 word nonzero", {31'b0, w1 != 0}, 32'h1);
    rd(5'h04, v); chk("R2 ready cleared by read", v & 32'h1, 32'h0);
    idle(GEN + 2);
    rd(5'h08, w2); chk("R2 second word nonzero", {31'b0, w2 != 0}, 32'h1);
    chk("R2 words differ", {31'b0, w1 != w2}, 32'h1);
    // R3 config acceptance
    curReq = "R3";
    wr(5'h00, 32'h00A00004);
    rd(5'h00, v); chk("R3 plain write ignored", v, 32'h00F00D04);
    wr(5'h00, 32'h40A00004);
    rd(5'h00, v); chk("R3 config taken with cond reset", v, 32'h40A00004);
    // R4 cond reset readback
    curReq = "R4";
    rd(5'h04, v); chk("R4 no ready while held", v & 32'h1, 32'h0);
    wr(5'h00, 32'h00A00004);
    rd(5'h00, v); chk("R4 busy after release", v, 32'h40A00004);
    idle(COND + 1);
    rd(5'h00, v); chk("R4 busy cleared", v, 32'h00A00004);
    // R9 clock error, R7 flag clear
    curReq = "R9";
    @(negedge clk); clkFault = 1'b1;
    rd(5'h04, v); chk("R9 clock flags set", v & 32'h22, 32'h22);
    clkFault = 1'b0;
    rd(5'h04, v); chk("R9 current follows input", v & 32'h22, 32'h20);
    curReq = "R7";
    wr(5'h04, 32'h20);
    rd(5'h04, v); chk("R7 write one keeps flag", v & 32'h20, 32'h20);
    wr(5'h04, 32'h0);
    rd(5'h04, v); chk("R7 write zero clears flag", v & 32'h20, 32'h0);
    curReq = "R9";
    wr(5'h00, 32'h40A00024);
    wr(5'h00, 32'h00A00024);
    idle(COND + 2);
    @(negedge clk); clkFault = 1'b1;
    rd(5'h04, v); chk("R9 detect disabled", v & 32'h22, 32'h0);
    clkFault = 1'b0;
    // R8 late seed fault, R5 recovery by cond reset
    curReq = "R8";
    idle(GEN + 2);
    fault(1'b0);
    rd(5'h04, v); chk("R8 flags with pending word", v & 32'h45, 32'h45);
    rd(5'h08, v); chk("R8 late word is zero", v, 32'h0);
    curReq = "R5";
    idle(GEN + 4);
    rd(5'h04, v); chk("R5 no word during fault", v & 32'h1, 32'h0);
    wr(5'h00, 32'h40A00024);
    wr(5'h00, 32'h00A00024);
    idle(COND + 2);
    rd(5'h04, v); chk("R5 current cleared by cond reset", v & 32'h44, 32'h40);
    curReq = "R7";
    wr(5'h04, 32'h0);
    rd(5'h04, v); chk("R7 seed flag cleared", v & 32'h40, 32'h0);
    curReq = "R5";
    idle(GEN + 2);
    rd(5'h04, v); chk("R5 generation resumed", v & 32'h1, 32'h1);
    // R6 auto recovery
    curReq = "R6";
    rd(5'h08, v);
    fault(1'b1);
    rd(5'h04, v); chk("R6 flags on fault", v & 32'h44, 32'h44);
    idle(AUTO + 2);
    rd(5'h04, v); chk("R6 auto cleared current only", v & 32'h44, 32'h40);
    idle(GEN + 2);
    rd(5'h04, v); chk("R6 words after auto", v & 32'h1, 32'h1);
    wr(5'h04, 32'h0);
    // R10 lock
    curReq = "R10";
    wr(5'h00, 32'h80A00024);
    rd(5'h00, v); chk("R10 lock set", v, 32'h80A00024);
    wr(5'h0C, 32'h0001_2345);
    rd(5'h0C, v); chk("R10 noise write ignored", v, 32'h0003FFFF);
    wr(5'h10, 32'h0);
    rd(5'h10, v); chk("R10 health write ignored", v, 32'h0000969D);
    wr(5'h00, 32'h40F00D04);
    rd(5'h00, v); chk("R10 config frozen", v, 32'hC0A00024);
    wr(5'h00, 32'h00F00D04);
    idle(COND + 2);
    rd(5'h00, v); chk("R10 lock stays", v, 32'h80A00024);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule